// File: doc/BRIEF.md
# Monitor Channel Receive Handshake

This block is the receiving end of a byte-wide monitor channel that is carried in a serial frame. A separate frame engine presents the downstream monitor byte and the downstream active-low transmit-request bit, and pulses a frame strobe once per frame. The block samples them on that strobe. It answers on the upstream active-low acknowledge bit, and it always sends an all-ones idle byte upstream while it is receiving.

A byte is accepted only when the same value is seen in two consecutive frames while the request bit is low. The accepted byte goes to a command consumer as a one-clock valid pulse. If the request bit stays high for two frames after an acknowledge, the block reports end-of-message. If the request bit rises before a byte has been confirmed, or if the consumer raises an external abort request, the block aborts the transfer. It does this by withholding the acknowledge for a set number of frames. After an abort or an end-of-message the channel must again see a quiet stretch before a new transfer can start.

Top module: `mon_rx_chan`

## Requirements
- R1: After reset the acknowledge output `mr_up_n` is high, and `byte_valid`, `eom` and `abort_pulse` are low.
- R2: A transfer starts only if, for the previous IDLE_FRAMES (default 2) frames, `mx_dn_n` and `mr_up_n` were both high. A low `mx_dn_n` before that point is ignored: no pulse is produced and `mr_up_n` stays high.
- R3: During a transfer, a byte is accepted when `mon_dn` carries the same value in two consecutive frames with `mx_dn_n` low. One clock after the strobe of the second frame, `byte_valid` pulses, `byte_data` holds that value and `mr_up_n` goes low. For the first byte of a transfer this is the frame right after `mx_dn_n` fell.
- R4: If the two frames differ, no acknowledge is given. The newer value becomes the reference, and acceptance happens as soon as two consecutive frames agree.
- R5: After an acknowledge, `mr_up_n` stays low while `mx_dn_n` stays low and through a single frame with `mx_dn_n` high. If `mx_dn_n` falls again after that single high frame, a new byte begins and `mr_up_n` returns high at that frame.
- R6: If `mx_dn_n` is high for two consecutive frames after an acknowledge, `eom` pulses for one clock and `mr_up_n` goes high.
- R7: If `mx_dn_n` goes high while a byte is still unconfirmed, `abort_pulse` pulses and no byte is delivered. `mr_up_n` then stays high for ABORT_FRAMES (default 2) frames, whatever `mx_dn_n` does during those frames.
- R8: A pulse on `abort_req` during a transfer produces the R7 abort at the next frame. A pulse on `abort_req` while the channel is idle has no effect.
- R9: After an end-of-message or an abort, a new transfer needs IDLE_FRAMES fresh frames with both bits high.
- R10: `mon_up` is all ones at all times.
- R11: `byte_valid`, `eom` and `abort_pulse` are one-clock pulses and are never active together. They and `mr_up_n` change only in the clock after a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-clock strobe, once per frame |
| mon_dn | input | DATA_W | Downstream monitor byte |
| mx_dn_n | input | 1 | Downstream transmit request, active low |
| abort_req | input | 1 | Consumer request to abort the current transfer |
| mr_up_n | output | 1 | Upstream acknowledge, active low |
| mon_up | output | DATA_W | Upstream monitor byte (all ones) |
| byte_valid | output | 1 | One-clock pulse with an accepted byte |
| byte_data | output | DATA_W | Last accepted byte |
| eom | output | 1 | One-clock end-of-message pulse |
| abort_pulse | output | 1 | One-clock abort pulse |

## Verification
The hardest situations to reach are the short ones. One is the single high frame between bytes, followed by a mismatching pair. The other is an external abort that arrives while the channel sits in that gap. Purely random request bits rarely build a confirmed byte before an abort interrupts it. For this reason the random stimulus draws the request bit low most of the time, and it draws the data from a two-value pool so that matches and mismatches happen about equally often. Directed sequences cover the early-start, re-arm and abort-during-gap cases exactly. Every frame is compared with a frame-level model in the bench.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_RECV  = 3'd1,
      RX_ACKED = 3'd2,
      RX_GAP   = 3'd3,
      RX_ABORT = 3'd4
   } rx_state_e;
endpackage

// File: rtl/mon_idle_det.sv
module mon_idle_det #(
   parameter int IDLE_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic enable,
   input  logic mx_n,
   input  logic mr_n,
   output logic armed
);
   localparam int CW = $clog2(IDLE_FRAMES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(IDLE_FRAMES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enable) begin
         cnt_q <= '0;
      end else if (frame_stb) begin
         if (mx_n && mr_n) begin
            if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign armed = (cnt_q == LIMIT);
endmodule

// File: rtl/mon_byte_cmp.sv
module mon_byte_cmp #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic              match,
   output logic [DATA_W-1:0] data_q
);
   logic [DATA_W-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         data_q <= '0;
      end else begin
         if (load) ref_q  <= din;
         if (take) data_q <= din;
      end
   end

   assign match = (din == ref_q);
endmodule

// File: rtl/mon_rx_fsm.sv
module mon_rx_fsm
   import mon_rx_pkg::*;
#(
   parameter int ABORT_FRAMES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_stb,
   input  logic      mx_n,
   input  logic      armed,
   input  logic      match,
   input  logic      abort_req,
   output rx_state_e state,
   output logic      load_ref,
   output logic      take,
   output logic      mr_n,
   output logic      valid_p,
   output logic      eom_p,
   output logic      abort_p
);
   localparam int AW = (ABORT_FRAMES > 1) ? $clog2(ABORT_FRAMES) : 1;
   localparam logic [AW-1:0] A_LAST = AW'(ABORT_FRAMES - 1);

   rx_state_e     st_q;
   logic          pend_q;
   logic [AW-1:0] acnt_q;
   logic          active;
   logic          go_abort;

   assign state    = st_q;
   assign active   = (st_q == RX_RECV) || (st_q == RX_ACKED) || (st_q == RX_GAP);
   assign go_abort = frame_stb && active && (pend_q || (st_q == RX_RECV && mx_n));

   always_comb begin
      load_ref = 1'b0;
      take     = 1'b0;
      if (frame_stb && !go_abort) begin
         unique case (st_q)
            RX_IDLE:  load_ref = armed && !mx_n;
            RX_RECV:  begin
               load_ref = !match;
               take     = match;
            end
            RX_GAP:   load_ref = !mx_n;
            default:  load_ref = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         pend_q  <= 1'b0;
         acnt_q  <= '0;
         mr_n    <= 1'b1;
         valid_p <= 1'b0;
         eom_p   <= 1'b0;
         abort_p <= 1'b0;
      end else begin
         valid_p <= 1'b0;
         eom_p   <= 1'b0;
         abort_p <= 1'b0;
         if (frame_stb) begin
            pend_q <= 1'b0;
         end else if (abort_req && active) begin
            pend_q <= 1'b1;
         end
         if (go_abort) begin
            st_q    <= RX_ABORT;
            mr_n    <= 1'b1;
            acnt_q  <= '0;
            abort_p <= 1'b1;
         end else if (frame_stb) begin
            unique case (st_q)
               RX_IDLE: begin
                  if (armed && !mx_n) st_q <= RX_RECV;
               end
               RX_RECV: begin
                  if (match) begin
                     st_q    <= RX_ACKED;
                     mr_n    <= 1'b0;
                     valid_p <= 1'b1;
                  end
               end
               RX_ACKED: begin
                  if (mx_n) st_q <= RX_GAP;
               end
               RX_GAP: begin
                  mr_n <= 1'b1;
                  if (mx_n) begin
                     st_q  <= RX_IDLE;
                     eom_p <= 1'b1;
                  end else begin
                     st_q <= RX_RECV;
                  end
               end
               RX_ABORT: begin
                  if (acnt_q == A_LAST) st_q <= RX_IDLE;
                  else acnt_q <= acnt_q + 1'b1;
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mon_rx_chan.sv
module mon_rx_chan
   import mon_rx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int IDLE_FRAMES  = 2,
   parameter int ABORT_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic [DATA_W-1:0] mon_dn,
   input  logic              mx_dn_n,
   input  logic              abort_req,
   output logic              mr_up_n,
   output logic [DATA_W-1:0] mon_up,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data,
   output logic              eom,
   output logic              abort_pulse
);
   generate
      if (DATA_W < 1)       begin : g_bad_w     $error("DATA_W must be at least 1");       end
      if (IDLE_FRAMES < 1)  begin : g_bad_idle  $error("IDLE_FRAMES must be at least 1");  end
      if (ABORT_FRAMES < 1) begin : g_bad_abort $error("ABORT_FRAMES must be at least 1"); end
   endgenerate

   rx_state_e state;
   logic      armed, match, load_ref, take;

   mon_idle_det #(.IDLE_FRAMES(IDLE_FRAMES)) i_idle (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
      .enable(state == RX_IDLE), .mx_n(mx_dn_n), .mr_n(mr_up_n),
      .armed(armed)
   );

   mon_byte_cmp #(.DATA_W(DATA_W)) i_cmp (
      .clk(clk), .rst_n(rst_n), .load(load_ref), .take(take),
      .din(mon_dn), .match(match), .data_q(byte_data)
   );

   mon_rx_fsm #(.ABORT_FRAMES(ABORT_FRAMES)) i_fsm (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mx_n(mx_dn_n),
      .armed(armed), .match(match), .abort_req(abort_req),
      .state(state), .load_ref(load_ref), .take(take), .mr_n(mr_up_n),
      .valid_p(byte_valid), .eom_p(eom), .abort_p(abort_pulse)
   );

   assign mon_up = '1;
endmodule

// File: rtl/mon_rx_chan_chk.sv
module mon_rx_chan_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb,
   input logic [DATA_W-1:0] mon_dn,
   input logic              mr_up_n,
   input logic              byte_valid,
   input logic [DATA_W-1:0] byte_data,
   input logic              eom,
   input logic              abort_pulse
);
   a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byte_valid, eom, abort_pulse}));

   a_r11_mr_moves_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mr_up_n) |-> $past(frame_stb));

   a_r11_pulse_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid || eom || abort_pulse) |-> $past(frame_stb));

   a_r3_ack_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> !mr_up_n);

   a_r3_data_is_sampled: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (byte_data == $past(mon_dn)));

   a_r6_eom_releases_mr: assert property (@(posedge clk) disable iff (!rst_n)
      eom |-> mr_up_n);

   a_r7_abort_withholds_mr: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> mr_up_n);

   a_r7_abort_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> !byte_valid);
endmodule

bind mon_rx_chan mon_rx_chan_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mon_dn(mon_dn),
   .mr_up_n(mr_up_n), .byte_valid(byte_valid), .byte_data(byte_data),
   .eom(eom), .abort_pulse(abort_pulse)
);

// File: tb/test_mon_rx_chan.sv
module test_mon_rx_chan;
   localparam int W  = 8;
   localparam int IF = 2;
   localparam int AF = 2;

   logic clk = 1'b0, rst_n = 1'b0, frame_stb = 1'b0, mx_dn_n = 1'b1, abort_req = 1'b0;
   logic [W-1:0] mon_dn = '1;
   logic mr_up_n, byte_valid, eom, abort_pulse;
   logic [W-1:0] mon_up, byte_data;

   int checks = 0, errors = 0;
   // bench model: 0 idle, 1 receiving, 2 acknowledged, 3 gap, 4 abort
   int m_st = 0, m_idle = 0, m_acnt = 0;
   logic [W-1:0] m_ref = '0;
   logic m_mr = 1'b1, m_pend = 1'b0;

   always #2.5 clk = ~clk;

   mon_rx_chan #(.DATA_W(W), .IDLE_FRAMES(IF), .ABORT_FRAMES(AF)) i_mon_rx_chan (.*);

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_abort(output logic ab);
      m_st = 4; m_mr = 1'b1; m_acnt = 0; ab = 1'b1;
   endtask

   task automatic model_step(input logic mx, input logic [W-1:0] d,
                             output logic bv, output logic em, output logic ab);
      logic arm;
      bv = 0; em = 0; ab = 0;
      arm = (m_idle >= IF);
      case (m_st)
         0: begin
            if (mx && m_mr) m_idle = (m_idle < IF) ? m_idle + 1 : m_idle;
            else m_idle = 0;
            if (arm && !mx) begin m_st = 1; m_ref = d; m_idle = 0; end
         end
         1: if (m_pend || mx) model_abort(ab);
            else if (d == m_ref) begin bv = 1; m_mr = 1'b0; m_st = 2; end
            else m_ref = d;
         2: if (m_pend) model_abort(ab);
            else if (mx) m_st = 3;
         3: if (m_pend) model_abort(ab);
            else if (mx) begin em = 1; m_mr = 1'b1; m_st = 0; m_idle = 0; end
            else begin m_mr = 1'b1; m_st = 1; m_ref = d; end
         default: if (m_acnt == AF - 1) begin m_st = 0; m_idle = 0; end
                  else m_acnt++;
      endcase
      m_pend = 1'b0;
   endtask

   task automatic frame(input logic mx, input logic [W-1:0] d, input string tag);
      logic bv, em, ab;
      model_step(mx, d, bv, em, ab);
      @(negedge clk);
      mx_dn_n = mx; mon_dn = d; frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      chk(tag, "mr_up_n", W'(mr_up_n), W'(m_mr));
      chk(tag, "byte_valid", W'(byte_valid), W'(bv));
      chk(tag, "eom", W'(eom), W'(em));
      chk(tag, "abort_pulse", W'(abort_pulse), W'(ab));
      if (bv) chk(tag, "byte_data", byte_data, d);
      @(negedge clk);
      chk("R11", "pulses cleared", W'({byte_valid, eom, abort_pulse}), '0);
      chk("R11", "mr_up_n between frames", W'(mr_up_n), W'(m_mr));
   endtask

   task automatic ext_abort();
      @(negedge clk);
      abort_req = 1'b1;
      if (m_st >= 1 && m_st <= 3) m_pend = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
   endtask

   initial begin
      logic [W-1:0] pool [2];
      void'($urandom(32'h5eed_0173));
      repeat (3) @(negedge clk);
      chk("R1", "mr_up_n in reset", W'(mr_up_n), W'(1'b1));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pulses after reset", W'({byte_valid, eom, abort_pulse}), '0);
      chk("R10", "mon_up", mon_up, '1);

      // R2: request before the channel is armed is ignored
      frame(1'b0, 8'h11, "R2");
      frame(1'b0, 8'h11, "R2");
      frame(1'b1, 8'h00, "R2");
      frame(1'b1, 8'h00, "R2");
      // R3: first byte acknowledged in the next frame
      frame(1'b0, 8'h42, "R3");
      frame(1'b0, 8'h42, "R3");
      chk("R10", "mon_up while receiving", mon_up, '1);
      // R5: MR held across a single gap frame, released on next byte
      frame(1'b0, 8'h42, "R5");
      frame(1'b1, 8'hff, "R5");
      frame(1'b0, 8'h10, "R5");
      // R4: mismatch, then a matching pair
      frame(1'b0, 8'h20, "R4");
      frame(1'b0, 8'h20, "R4");
      // R6: two high frames end the message
      frame(1'b1, 8'hff, "R6");
      frame(1'b1, 8'hff, "R6");
      // R9: a single quiet frame is not enough to re-arm
      frame(1'b1, 8'hff, "R9");
      frame(1'b0, 8'h33, "R9");
      frame(1'b1, 8'hff, "R9");
      frame(1'b1, 8'hff, "R9");
      // R7: request released before confirmation
      frame(1'b0, 8'h05, "R7");
      frame(1'b1, 8'hff, "R7");
      frame(1'b0, 8'h06, "R7");
      frame(1'b0, 8'h06, "R7");
      repeat (IF) frame(1'b1, 8'hff, "R9");
      // R8: external abort in idle is ignored, in a gap it aborts
      ext_abort();
      frame(1'b0, 8'h07, "R8");
      frame(1'b0, 8'h07, "R8");
      frame(1'b1, 8'hff, "R8");
      ext_abort();
      frame(1'b0, 8'h08, "R8");
      repeat (AF + IF) frame(1'b1, 8'hff, "R8");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic mx;
         logic [W-1:0] d;
         if (n % 200 == 0) begin
            pool[0] = W'($urandom);
            pool[1] = W'($urandom);
         end
         mx = ($urandom_range(0, 9) < 3);
         d  = ($urandom_range(0, 19) == 0) ? W'($urandom) : pool[$urandom_range(0, 1)];
         if ($urandom_range(0, 39) == 0) ext_abort();
         frame(mx, d, "R3R4R5R6R7R8");
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule